// File: doc/BRIEF.md
# Vendor-Specific Capability Walker

This block follows the linked list of capabilities in a device's PCI configuration space and collects the locations of the structures that a paravirtual device advertises through vendor-specific capabilities. A `start` pulse and a head pointer begin a walk. The walker fetches each capability header one dword at a time through a read port. When the capability ID marks an entry as vendor specific, it decodes the configuration-type byte and records the BAR index, offset and length in one result slot per type. The notify type has one extra trailing dword, and the walker records it as the notify offset multiplier.

The read port is a request stream. The walker raises `rd_valid` with a dword-aligned byte address and holds both until `rd_ready` is seen high at a clock edge. The responder may apply back-pressure for any number of cycles. The responder gives no response handshake. The data word must be on `rd_data` during the cycle that ends `RD_LAT` clock edges after the accepting edge, and the walker samples it at that edge. Only one request is outstanding at a time. The result ports hold their values between walks. Software-free logic reads the results once `done` pulses.

Top module: `cw_cap_walker`

## Requirements
- R1: Out of reset, `busy`, `done`, `err`, `unknown_seen`, `rd_valid` and every bit of `kind_valid` are 0.
- R2: A `start` seen while idle raises `busy` from the next cycle. At completion, `done` is high for one cycle and `busy` is low in that cycle. A `start` seen while `busy` is high is ignored, and the address sequence of the current walk is unchanged.
- R3: `rd_valid` stays high with a stable `rd_addr` until accepted, and every address has bits [1:0] equal to 0. Read data is taken `RD_LAT` edges after the accepting edge.
- R4: The walker reads the header dword at the capability pointer. Byte 0 of that dword is the ID and byte 1 is the next pointer. Only ID 0x09 is decoded, and any other ID costs exactly one read. A next pointer of zero ends the walk. The low two bits of a pointer are ignored.
- R5: Byte 3 of the header is the type. Types 1 to 5 select a slot, and `kind_valid[type-1]` marks that slot. For a vendor entry whose slot is still empty, the walker reads pointer+4, pointer+8 and pointer+12 in that order. It takes the BAR index from byte 0 of the +4 dword, the offset from the +8 dword and the length from the +12 dword.
- R6: Only type 2 causes a fifth read at pointer+16, and that dword appears on `notify_mult`.
- R7: Slot k (type k+1) appears on `kind_bar[8k+7:8k]`, `kind_off[32k+31:32k]` and `kind_len[32k+31:32k]`. Slots are filled independently even when they name the same BAR.
- R8: When a type repeats within one walk, the first entry's values are kept and the repeat costs only its header read.
- R9: A vendor entry whose type is outside 1 to 5 sets `unknown_seen`, costs only its header read, and the walk continues.
- R10: At most 48 headers are read per walk. If the 48th header's next pointer is nonzero, the walk ends with `err` high and `done`, and no further read is made. A chain of exactly 48 entries completes without error.
- R11: A head pointer of zero gives `done` in the cycle after `start`, with no read.
- R12: An accepted `start` clears `kind_valid`, `err` and `unknown_seen`. These outputs do not change while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| head_ptr | input | ADDR_W | First capability pointer |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Walk aborted by the visit limit |
| unknown_seen | output | 1 | A vendor entry of unknown type was met |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted at this edge |
| rd_addr | output | ADDR_W | Dword-aligned byte address |
| rd_data | input | 32 | Read data, RD_LAT edges after acceptance |
| kind_valid | output | NUM_KINDS | Slot filled, bit k for type k+1 |
| kind_bar | output | NUM_KINDS*8 | BAR index per slot |
| kind_off | output | NUM_KINDS*32 | Offset within the BAR per slot |
| kind_len | output | NUM_KINDS*32 | Structure length per slot |
| notify_mult | output | 32 | Notify offset multiplier |

## Verification
The assertions assume that the responder never changes an accepted word's timing: data lands exactly `RD_LAT` edges after acceptance, whatever `rd_ready` does in between. They also assume that `start` is only a pulse and that it never coincides with a cycle in which `done` is high. The bench's memory model is a two-stage address pipeline that fixes the latency at 2. It toggles `rd_ready` in a repeating stall pattern during some walks, and it spaces every `start` at least one idle cycle after `done`. Chains are built from aligned and deliberately unaligned pointers, repeated and unknown types, and self-looping tails, so that the visit limit, the first-kept rule and pointer masking are all reached.

// File: rtl/cw_pkg.sv
package cw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;

  localparam logic [7:0] VENDOR_CAP_ID = 8'h09;
  localparam logic [2:0] KIND_NOTIFY   = 3'd2;
  localparam logic [2:0] LAST_STD_WORD = 3'd3;
  localparam logic [2:0] MULT_WORD     = 3'd4;
endpackage

// File: rtl/cw_rd_port.sv
module cw_rd_port #(
  parameter int ADDR_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accepted,
  output logic              rsp_stb
);
  logic [RD_LAT-1:0] pend_q;

  assign rd_valid = issue;
  assign rd_addr  = addr_in;
  assign accepted = issue && rd_ready;

  generate
    if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= accepted;
      end
    end else begin : g_latn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= {pend_q[RD_LAT-2:0], accepted};
      end
    end
  endgenerate

  assign rsp_stb = pend_q[RD_LAT-1];
endmodule

// File: rtl/cw_slot_bank.sv
module cw_slot_bank #(
  parameter int NUM_KINDS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr,
  input  logic [2:0]              kind,
  input  logic [7:0]              bar_in,
  input  logic [31:0]             off_in,
  input  logic [31:0]             len_in,
  input  logic [31:0]             mult_in,
  output logic [NUM_KINDS-1:0]    kind_valid,
  output logic [NUM_KINDS*8-1:0]  kind_bar,
  output logic [NUM_KINDS*32-1:0] kind_off,
  output logic [NUM_KINDS*32-1:0] kind_len,
  output logic [31:0]             notify_mult
);
  import cw_pkg::*;

  logic [7:0]  bar_q [NUM_KINDS];
  logic [31:0] off_q [NUM_KINDS];
  logic [31:0] len_q [NUM_KINDS];

  generate
    for (genvar i = 0; i < NUM_KINDS; i++) begin : g_slot
      logic hit;
      assign hit = wr && (kind == 3'(i + 1)) && !kind_valid[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          kind_valid[i] <= 1'b0;
          bar_q[i]      <= '0;
          off_q[i]      <= '0;
          len_q[i]      <= '0;
        end else if (clr) begin
          kind_valid[i] <= 1'b0;
        end else if (hit) begin
          kind_valid[i] <= 1'b1;
          bar_q[i]      <= bar_in;
          off_q[i]      <= off_in;
          len_q[i]      <= len_in;
        end
      end
      assign kind_bar[i*8 +: 8]   = bar_q[i];
      assign kind_off[i*32 +: 32] = off_q[i];
      assign kind_len[i*32 +: 32] = len_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) notify_mult <= '0;
    else if (wr && kind == KIND_NOTIFY && !kind_valid[KIND_NOTIFY-1])
      notify_mult <= mult_in;
  end
endmodule

// File: rtl/cw_cap_walker.sv
module cw_cap_walker #(
  parameter int ADDR_W    = 8,
  parameter int RD_LAT    = 2,
  parameter int MAX_CAPS  = 48,
  parameter int NUM_KINDS = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       head_ptr,
  output logic                    busy,
  output logic                    done,
  output logic                    err,
  output logic                    unknown_seen,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic [31:0]             rd_data,
  output logic [NUM_KINDS-1:0]    kind_valid,
  output logic [NUM_KINDS*8-1:0]  kind_bar,
  output logic [NUM_KINDS*32-1:0] kind_off,
  output logic [NUM_KINDS*32-1:0] kind_len,
  output logic [31:0]             notify_mult
);
  import cw_pkg::*;

  localparam int VIS_W = $clog2(MAX_CAPS + 1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  walk_st_e          state_q;
  logic [ADDR_W-1:0] cur_ptr_q, next_ptr_q;
  logic [2:0]        word_q, kind_q;
  logic [VIS_W-1:0]  visits_q;
  logic [7:0]        bar_q;
  logic [31:0]       off_q, len_q;

  logic              issue, accepted, rsp_stb, rsp;
  logic [ADDR_W-1:0] req_addr;
  logic              clr;

  // header decode
  logic [7:0]        hdr_id, hdr_next, hdr_type;
  logic              type_ok, is_vendor, slot_free, take;
  logic [2:0]        type_k;
  logic              wr, do_adv;
  logic [ADDR_W-1:0] adv_ptr;
  logic [VIS_W-1:0]  adv_vis;
  logic [31:0]       wr_len;
  logic              unused_bits;

  assign busy     = (state_q != ST_IDLE);
  assign issue    = (state_q == ST_REQ);
  assign req_addr = cur_ptr_q + ADDR_W'({word_q, 2'b00});
  assign clr      = start && !busy;
  assign rsp      = (state_q == ST_WAIT) && rsp_stb;

  cw_rd_port #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .addr_in(req_addr),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .accepted(accepted), .rsp_stb(rsp_stb)
  );

  assign hdr_id    = rd_data[7:0];
  assign hdr_next  = rd_data[15:8];
  assign hdr_type  = rd_data[31:24];
  assign unused_bits = ^{rd_data[23:16]};
  assign is_vendor = (hdr_id == VENDOR_CAP_ID);
  assign type_ok   = (hdr_type >= 8'd1) && (hdr_type <= 8'(NUM_KINDS));
  assign type_k    = hdr_type[2:0];
  assign slot_free = type_ok &&
                     ((kind_valid & (NUM_KINDS'(1) << (type_k - 3'd1))) == '0);
  assign take      = (word_q == 3'd0) && is_vendor && slot_free;

  assign wr = rsp && (((word_q == LAST_STD_WORD) && (kind_q != KIND_NOTIFY)) ||
                      (word_q == MULT_WORD));
  assign wr_len  = (word_q == LAST_STD_WORD) ? rd_data : len_q;
  assign do_adv  = (rsp && (word_q == 3'd0) && !take) || wr;
  assign adv_ptr = ((word_q == 3'd0) ? ADDR_W'(hdr_next) : next_ptr_q) & ALIGN_MASK;
  assign adv_vis = (word_q == 3'd0) ? visits_q + VIS_W'(1) : visits_q;

  cw_slot_bank #(.NUM_KINDS(NUM_KINDS)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .kind(kind_q),
    .bar_in(bar_q), .off_in(off_q), .len_in(wr_len), .mult_in(rd_data),
    .kind_valid(kind_valid), .kind_bar(kind_bar), .kind_off(kind_off),
    .kind_len(kind_len), .notify_mult(notify_mult)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_ptr_q    <= '0;
      next_ptr_q   <= '0;
      word_q       <= '0;
      kind_q       <= '0;
      visits_q     <= '0;
      bar_q        <= '0;
      off_q        <= '0;
      len_q        <= '0;
      done         <= 1'b0;
      err          <= 1'b0;
      unknown_seen <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        err          <= 1'b0;
        unknown_seen <= 1'b0;
        visits_q     <= '0;
        word_q       <= '0;
        cur_ptr_q    <= head_ptr & ALIGN_MASK;
        if ((head_ptr & ALIGN_MASK) == '0) done <= 1'b1;
        else state_q <= ST_REQ;
      end else if (state_q == ST_REQ) begin
        if (accepted) state_q <= ST_WAIT;
      end else if (rsp) begin
        if (word_q == 3'd0) begin
          visits_q   <= adv_vis;
          next_ptr_q <= ADDR_W'(hdr_next);
          if (is_vendor && !type_ok) unknown_seen <= 1'b1;
          if (take) begin
            kind_q  <= type_k;
            word_q  <= 3'd1;
            state_q <= ST_REQ;
          end
        end else if (!wr) begin
          case (word_q)
            3'd1:    bar_q <= rd_data[7:0];
            3'd2:    off_q <= rd_data;
            default: len_q <= rd_data;
          endcase
          word_q  <= word_q + 3'd1;
          state_q <= ST_REQ;
        end
        if (do_adv) begin
          if (adv_ptr == '0) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else if (adv_vis >= VIS_W'(MAX_CAPS)) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            err     <= 1'b1;
          end else begin
            cur_ptr_q <= adv_ptr;
            word_q    <= 3'd0;
            state_q   <= ST_REQ;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cw_walker_chk.sv
module cw_walker_chk #(
  parameter int ADDR_W    = 8,
  parameter int MAX_CAPS  = 48,
  parameter int NUM_KINDS = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 err,
  input logic                 rd_valid,
  input logic                 rd_ready,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic [NUM_KINDS-1:0] kind_valid
);
  int unsigned reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 reads_q <= 0;
    else if (start && !busy)    reads_q <= 0;
    else if (rd_valid && rd_ready) reads_q <= reads_q + 1;
  end

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R3
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[1:0] == 2'b00);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R10
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  // R10
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= MAX_CAPS * 5);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(kind_valid) && $stable(err));
endmodule

bind cw_cap_walker cw_walker_chk #(
  .ADDR_W(ADDR_W), .MAX_CAPS(MAX_CAPS), .NUM_KINDS(NUM_KINDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .kind_valid(kind_valid)
);

// File: tb/tb_cw_cap_walker.sv
`timescale 1ns/1ps
module tb_cw_cap_walker;
  localparam int AW = 8;
  localparam int NK = 5;
  localparam int MAXC = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] head_ptr = '0;
  logic busy, done, err, unknown_seen, rd_valid;
  logic rd_ready = 1'b1;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data;
  logic [NK-1:0] kind_valid;
  logic [NK*8-1:0] kind_bar;
  logic [NK*32-1:0] kind_off, kind_len;
  logic [31:0] notify_mult;

  always #2.5 clk = ~clk;

  cw_cap_walker #(.ADDR_W(AW), .RD_LAT(2), .MAX_CAPS(MAXC), .NUM_KINDS(NK)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr), .busy(busy),
    .done(done), .err(err), .unknown_seen(unknown_seen), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .kind_valid(kind_valid), .kind_bar(kind_bar), .kind_off(kind_off),
    .kind_len(kind_len), .notify_mult(notify_mult)
  );

  // configuration-space memory, latency 2
  logic [31:0] mem [0:63];
  logic [AW-1:0] pa0, pa1;
  always @(posedge clk) begin
    pa0 <= rd_addr;
    pa1 <= pa0;
  end
  assign rd_data = mem[pa1[7:2]];

  int checks = 0, fails = 0, cyc = 0;
  bit stall_mode = 0;
  int exp_addr[$];
  bit ev[NK];
  logic [7:0] eb[NK];
  logic [31:0] eo[NK], el[NK], em;
  bit eerr, eunk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // every clock: compare read handshakes against the expected address order
  always @(negedge clk) begin
    cyc++;
    rd_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_addr.size() == 0) chk(0, "R4 unexpected read", 32'(rd_addr), 32'hFFFF);
      else begin
        int a;
        a = exp_addr.pop_front();
        chk(rd_addr == AW'(a), "R3/R5 read address", 32'(rd_addr), 32'(a));
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic put_cap(input int p, input logic [7:0] id, input logic [7:0] nxt,
                         input logic [7:0] typ, input logic [7:0] bar,
                         input logic [31:0] off, input logic [31:0] len, input logic [31:0] mult);
    mem[p/4]     = {typ, (typ == 8'd2) ? 8'h14 : 8'h10, nxt, id};
    mem[p/4 + 1] = {24'h0, bar};
    mem[p/4 + 2] = off;
    mem[p/4 + 3] = len;
    mem[p/4 + 4] = mult;
  endtask

  // behavioural expectation from the requirements
  task automatic build_expect(input int head);
    int p, vis;
    exp_addr.delete();
    for (int k = 0; k < NK; k++) begin ev[k] = 0; eb[k] = 0; eo[k] = 0; el[k] = 0; end
    eerr = 0; eunk = 0;
    p = head & 'hFC; vis = 0;
    while (p != 0) begin
      logic [31:0] h;
      int t;
      if (vis == MAXC) begin eerr = 1; break; end
      h = mem[p/4]; vis++;
      exp_addr.push_back(p);
      t = h[31:24];
      if (h[7:0] == 8'h09) begin
        if (t >= 1 && t <= 5) begin
          if (!ev[t-1]) begin
            exp_addr.push_back(p+4); exp_addr.push_back(p+8); exp_addr.push_back(p+12);
            ev[t-1] = 1; eb[t-1] = mem[p/4+1][7:0]; eo[t-1] = mem[p/4+2]; el[t-1] = mem[p/4+3];
            if (t == 2) begin exp_addr.push_back(p+16); em = mem[p/4+4]; end
          end
        end else eunk = 1;
      end
      p = h[15:8] & 'hFC;
    end
  endtask

  task automatic run_walk(input int head, input bit mid_start, input string tag);
    int n;
    build_expect(head);
    @(negedge clk);
    head_ptr = AW'(head); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done) begin
      chk(busy == 1'b1, "R2 busy during walk", 32'(busy), 1);
      if (mid_start && n == 6) begin head_ptr = 8'h90; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      n++;
      if (n > 2000) begin chk(0, "watchdog", 0, 1); break; end
    end
    start = 1'b0;
    chk(busy == 1'b0, {"R2 busy low at done ", tag}, 32'(busy), 0);
    chk(exp_addr.size() == 0, {"R4 reads missing ", tag}, exp_addr.size(), 0);
    chk(err == eerr, {"R10 err ", tag}, 32'(err), 32'(eerr));
    chk(unknown_seen == eunk, {"R9 unknown ", tag}, 32'(unknown_seen), 32'(eunk));
    for (int k = 0; k < NK; k++) begin
      chk(kind_valid[k] == ev[k], {"R5 slot valid ", tag}, 32'(kind_valid[k]), 32'(ev[k]));
      if (ev[k]) begin
        chk(kind_bar[k*8 +: 8] == eb[k], {"R7 bar ", tag}, 32'(kind_bar[k*8 +: 8]), 32'(eb[k]));
        chk(kind_off[k*32 +: 32] == eo[k], {"R7 off ", tag}, kind_off[k*32 +: 32], eo[k]);
        chk(kind_len[k*32 +: 32] == el[k], {"R7 len ", tag}, kind_len[k*32 +: 32], el[k]);
      end
    end
    if (ev[1]) chk(notify_mult == em, {"R6 mult ", tag}, notify_mult, em);
    @(negedge clk);
    chk(done == 1'b0, {"R2 done one cycle ", tag}, 32'(done), 0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    $display("FAIL watchdog: actual timeout expected finish");
    fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, err, unknown_seen, rd_valid} == 5'b0, "R1 reset outputs", 32'({busy, done, err, unknown_seen, rd_valid}), 0);
    chk(kind_valid == '0, "R1 reset slots", 32'(kind_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // main chain: non-vendor entry, unaligned pointer (R4), unknown (R9), repeat (R8), shared BAR (R7)
    put_cap(8'h40, 8'h09, 8'h50, 8'd1, 8'd4, 32'h0,    32'h1000, 32'h0);
    mem[8'h50/4] = {8'h00, 8'h08, 8'h55, 8'h05};
    put_cap(8'h54, 8'h09, 8'h6C, 8'd2, 8'd4, 32'h3000, 32'h1000, 32'h4);
    mem[8'h6C/4] = {8'h07, 8'h10, 8'h70, 8'h09};
    put_cap(8'h70, 8'h09, 8'h80, 8'd3, 8'd2, 32'h1000, 32'h20,   32'h0);
    put_cap(8'h80, 8'h09, 8'h90, 8'd3, 8'd5, 32'h9000, 32'h40,   32'h0);
    put_cap(8'h90, 8'h09, 8'h00, 8'd5, 8'd0, 32'h0,    32'h0,    32'h0);
    run_walk(8'h40, 0, "R8 chain");
    stall_mode = 1;
    run_walk(8'h40, 0, "R3 stalled chain");
    // R2: start during busy is ignored
    run_walk(8'h40, 1, "R2 start while busy");
    stall_mode = 0;

    // R11 / R12: head zero clears results and reads nothing
    run_walk(0, 0, "R11 head zero");
    chk(kind_valid == '0, "R12 slots cleared", 32'(kind_valid), 0);

    // R6: notify entry reached second, device-specific first, stalls
    clear_mem();
    put_cap(8'hA0, 8'h09, 8'h40, 8'd4, 8'd1, 32'h2000, 32'h100, 32'h0);
    put_cap(8'h40, 8'h09, 8'h00, 8'd2, 8'd3, 32'h5000, 32'h800, 32'h10);
    stall_mode = 1;
    run_walk(8'hA0, 0, "R6 notify");
    stall_mode = 0;

    // R10: exactly 48 entries pass, a looped chain aborts
    clear_mem();
    for (int i = 0; i < MAXC; i++)
      mem[16 + i] = {8'h00, 8'h04, (i == MAXC-1) ? 8'h00 : 8'(8'h44 + 4*i), 8'h10};
    run_walk(8'h40, 0, "R10 48 entries");
    mem[63] = {8'h00, 8'h04, 8'h40, 8'h10};
    run_walk(8'h40, 0, "R10 looped chain");
    chk(err == 1'b1, "R10 err held idle", 32'(err), 1);
    run_walk(0, 0, "R12 clears err");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule